// File: doc/BRIEF.md
# Dual-chain NAND tree connectivity test controller

This block lets board-level test equipment check that every input pad of the chip is soldered and connected, with no scan clock or boundary-scan logic. A static code on four test-control pins puts the chip into this mode. The decode is purely combinational, so the mode starts and ends as soon as the pin levels change. While the mode is active, the values arriving from the input pads feed two independent NAND-tree chains. Chain one has 24 stages and chain two has 16. Each chain result drives out on a functional output pad that is borrowed for the purpose.

While the mode is active, every other output driver goes to high impedance. The one exception is the test data output pad, which keeps its functional enable. The tester can then drive each pad freely and watch the two result pads. Outside the mode, the borrowed pads and all output enables carry their functional values untouched.

Top module: `nandt_ctrl`

## Requirements
- R1: The mode is active only when test_en=1, test_clk=0, test_exec=1 and test_in=1 together. Every other combination of these four pins is normal operation.
- R2: Chain one takes pad_in[p-1] as chain position p (p=1..24). Chain two takes pad_in[24+p-1] as position p (p=1..16). Stage p computes NAND(stage p-1, position p), and stage 0 is a constant 1. The last stage is the chain result.
- R3: If the inputs are all 1 and the positions are driven to 0 one after another from position 1, keeping earlier ones at 0, the chain result flips at every step.
- R4: With every input of a chain at 1, the result is 1 when the chain length is even. This applies to both default chains.
- R5: A chain input held at 0 at position s masks positions 1..s-1. While it is held, changing those inputs does not change the result, which equals 1 when (length - s) is even and 0 otherwise.
- R6: In test mode, pad_oe bit TDO_IDX (default 0) equals func_oe bit TDO_IDX. Bits P1_IDX and P2_IDX (defaults 1 and 2) are 1, and every other bit is 0.
- R7: In test mode, pad1_out carries the chain-one result and pad2_out carries the chain-two result.
- R8: Outside test mode, pad_oe equals func_oe, pad1_out equals func_d1 and pad2_out equals func_d2. This holds from the same evaluation in which the mode is left.
- R9: The two chains are independent. Changing chain-two inputs never changes the chain-one result, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_en | input | 1 | Test-control pin, must be 1 for the mode |
| test_clk | input | 1 | Test-control pin, must be 0 for the mode |
| test_exec | input | 1 | Test-control pin, must be 1 for the mode |
| test_in | input | 1 | Test-control pin, must be 1 for the mode |
| pad_in | input | 40 | Input-buffer outputs, chain one in bits 23:0, chain two in bits 39:24 |
| func_oe | input | 32 | Functional output enables, one per output pad |
| func_d1 | input | 1 | Functional data for the first borrowed pad |
| func_d2 | input | 1 | Functional data for the second borrowed pad |
| pad_oe | output | 32 | Output enables sent to the pads |
| pad1_out | output | 1 | First borrowed pad data: chain-one result in test mode |
| pad2_out | output | 1 | Second borrowed pad data: chain-two result in test mode |

## Verification
Leaving the mode and a change on the pad inputs can happen in the same evaluation step. In that case the borrowed pads must switch back to functional data at once, with no chain value left on them. The bench provokes this by changing the control code, pad_in, func_oe and the functional data in one drive after a chain has been walked to a known state. The scoreboard item for that step expects only functional values on every output. A chain input change inside the mode, made together with a change on func_oe, is judged in the same way: the result pads must follow the chains, and only the test data output enable may follow func_oe.

// File: rtl/nandt_pkg.sv
// Package: shared definitions for the NAND tree test controller.
// Assumes the four control pins are sampled as static levels.
package nandt_pkg;
    // Levels of the four control pins, grouped for the decode.
    typedef struct packed {
        logic en;
        logic clk;
        logic exec;
        logic din;
    } tcode_t;

    // Static entry code: en=1, clk=0, exec=1, din=1.
    localparam tcode_t ENTRY_CODE = '{en: 1'b1, clk: 1'b0, exec: 1'b1, din: 1'b1};
endpackage

// File: rtl/nandt_mode_decode.sv
// Module: combinational decode of the static test entry code.
// Assumes no clock: the mode follows the pin levels with no state.
module nandt_mode_decode
    import nandt_pkg::*;
(
    input  tcode_t code,
    output logic   mode_on
);
    // Match the pins against the entry code.
    always_comb begin
        mode_on = (code == ENTRY_CODE);
    end
endmodule

// File: rtl/nandt_chain.sv
// Module: one ordered NAND tree chain of LEN stages.
// Position p of the chain is taps[p-1]. Stage 0 is a constant 1.
// Assumes LEN >= 1.
module nandt_chain #(
    parameter int LEN = 24
) (
    input  logic [LEN-1:0] taps,
    output logic           result
);
    logic [LEN:0] node;

    assign node[0] = 1'b1;

    // Build one NAND stage per chain position.
    for (genvar g = 0; g < LEN; g++) begin : g_stage
        assign node[g+1] = ~(node[g] & taps[g]);
    end

    assign result = node[LEN];

    // A zero on the last position forces the result high (R5 at s = LEN).
    always_comb begin
        if (taps[LEN-1] == 1'b0) begin
            p_tail_mask_r5: assert (result == 1'b1)
                else $error("chain tail zero did not force result high");
        end
    end
endmodule

// File: rtl/nandt_pad_ctrl.sv
// Module: forces output enables and muxes chain results onto borrowed pads.
// Assumes the three special pad indices are distinct and below N_OUT.
module nandt_pad_ctrl #(
    parameter int N_OUT   = 32,
    parameter int TDO_IDX = 0,
    parameter int P1_IDX  = 1,
    parameter int P2_IDX  = 2
) (
    input  logic             mode_on,
    input  logic [N_OUT-1:0] func_oe,
    input  logic             func_d1,
    input  logic             func_d2,
    input  logic             res1,
    input  logic             res2,
    output logic [N_OUT-1:0] pad_oe,
    output logic             pad1_out,
    output logic             pad2_out
);
    // Pick the enable of each pad according to its role.
    for (genvar g = 0; g < N_OUT; g++) begin : g_oe
        if (g == TDO_IDX) begin : g_tdo
            assign pad_oe[g] = func_oe[g];
        end else if (g == P1_IDX || g == P2_IDX) begin : g_borrow
            assign pad_oe[g] = mode_on | func_oe[g];
        end else begin : g_plain
            assign pad_oe[g] = mode_on ? 1'b0 : func_oe[g];
        end
    end

    // Put the chain results on the borrowed pads while in the mode.
    always_comb begin
        pad1_out = mode_on ? res1 : func_d1;
        pad2_out = mode_on ? res2 : func_d2;
    end
endmodule

// File: rtl/nandt_ctrl.sv
// Module: top of the dual-chain NAND tree connectivity test controller.
// Chain one uses pad_in[CH1_LEN-1:0] and chain two uses the bits above.
// Assumes a purely combinational block: no clock and no reset.
module nandt_ctrl
    import nandt_pkg::*;
#(
    parameter int CH1_LEN = 24,
    parameter int CH2_LEN = 16,
    parameter int N_OUT   = 32,
    parameter int TDO_IDX = 0,
    parameter int P1_IDX  = 1,
    parameter int P2_IDX  = 2
) (
    input  logic                       test_en,
    input  logic                       test_clk,
    input  logic                       test_exec,
    input  logic                       test_in,
    input  logic [CH1_LEN+CH2_LEN-1:0] pad_in,
    input  logic [N_OUT-1:0]           func_oe,
    input  logic                       func_d1,
    input  logic                       func_d2,
    output logic [N_OUT-1:0]           pad_oe,
    output logic                       pad1_out,
    output logic                       pad2_out
);
    localparam int N_IN = CH1_LEN + CH2_LEN;
    localparam logic [N_OUT-1:0] KEEP_MASK =
        (N_OUT'(1) << P1_IDX) | (N_OUT'(1) << P2_IDX);

    tcode_t code;
    logic   mode_on;
    logic   res1;
    logic   res2;

    // Gather the four control pins into one code word.
    always_comb begin
        code = '{en: test_en, clk: test_clk, exec: test_exec, din: test_in};
    end

    nandt_mode_decode u_decode (
        .code    (code),
        .mode_on (mode_on)
    );

    nandt_chain #(.LEN(CH1_LEN)) u_chain1 (
        .taps   (pad_in[CH1_LEN-1:0]),
        .result (res1)
    );

    nandt_chain #(.LEN(CH2_LEN)) u_chain2 (
        .taps   (pad_in[N_IN-1:CH1_LEN]),
        .result (res2)
    );

    nandt_pad_ctrl #(
        .N_OUT   (N_OUT),
        .TDO_IDX (TDO_IDX),
        .P1_IDX  (P1_IDX),
        .P2_IDX  (P2_IDX)
    ) u_pads (
        .mode_on  (mode_on),
        .func_oe  (func_oe),
        .func_d1  (func_d1),
        .func_d2  (func_d2),
        .res1     (res1),
        .res2     (res2),
        .pad_oe   (pad_oe),
        .pad1_out (pad1_out),
        .pad2_out (pad2_out)
    );

    // Cross-module checks on the pad side of the block.
    always_comb begin
        if (mode_on) begin
            p_hiz_r6: assert ((pad_oe & ~KEEP_MASK & ~(N_OUT'(1) << TDO_IDX)) == '0)
                else $error("output enable left on in test mode");
            p_borrow_r7: assert (pad1_out == res1 && pad2_out == res2)
                else $error("chain result missing on borrowed pad");
        end else begin
            p_normal_r8: assert (pad_oe == func_oe && pad1_out == func_d1
                                 && pad2_out == func_d2)
                else $error("functional pad values altered outside test mode");
        end
        if (pad_in[N_IN-1] == 1'b0 && mode_on) begin
            p_ch2_tail_r9: assert (pad2_out == 1'b1)
                else $error("chain two tail zero not seen on its own pad");
        end
    end
endmodule

// File: tb/nandt_ctrl_tb_top.sv
// Scoreboard bench: the driver pushes expected pad values, the monitor compares.
module nandt_ctrl_tb_top;
    localparam int L1 = 24;
    localparam int L2 = 16;
    localparam int NI = L1 + L2;
    localparam int NO = 32;

    typedef struct {
        logic [NO-1:0] oe;
        logic          d1;
        logic          d2;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic          test_en, test_clk, test_exec, test_in;
    logic [NI-1:0] pad_in;
    logic [NO-1:0] func_oe;
    logic          func_d1, func_d2;
    logic [NO-1:0] pad_oe;
    logic          pad1_out, pad2_out;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    nandt_ctrl dut_i (
        .test_en   (test_en),
        .test_clk  (test_clk),
        .test_exec (test_exec),
        .test_in   (test_in),
        .pad_in    (pad_in),
        .func_oe   (func_oe),
        .func_d1   (func_d1),
        .func_d2   (func_d2),
        .pad_oe    (pad_oe),
        .pad1_out  (pad1_out),
        .pad2_out  (pad2_out)
    );

    // Expected chain result from the last zero position.
    function automatic logic chain_ref(input logic [NI-1:0] v, input int base, input int len);
        int last = 0;
        for (int p = 1; p <= len; p++) if (v[base+p-1] == 1'b0) last = p;
        if (last == 0) return ((len % 2) == 0);
        return (((len - last) % 2) == 0);
    endfunction

    // Drive one stimulus and push the expected pad values.
    task automatic apply(input logic [3:0] c, input logic [NI-1:0] v,
                         input logic [NO-1:0] foe, input logic fd1, input logic fd2,
                         input string tag);
        exp_t e;
        bit   on;
        @(posedge clk);
        #1;
        {test_en, test_clk, test_exec, test_in} = c;
        pad_in = v; func_oe = foe; func_d1 = fd1; func_d2 = fd2;
        on = (c == 4'b1011);
        if (on) begin
            e.oe = '0;
            e.oe[0] = foe[0];
            e.oe[1] = 1'b1;
            e.oe[2] = 1'b1;
            e.d1 = chain_ref(v, 0, L1);
            e.d2 = chain_ref(v, L1, L2);
        end else begin
            e.oe = foe; e.d1 = fd1; e.d2 = fd2;
        end
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Compare the pads against the oldest expected item.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (pad_oe !== e.oe || pad1_out !== e.d1 || pad2_out !== e.d2) begin
                n_errors++;
                $display("FAIL %s: got oe=%h d1=%b d2=%b expected oe=%h d1=%b d2=%b",
                         e.tag, pad_oe, pad1_out, pad2_out, e.oe, e.d1, e.d2);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 100000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [NI-1:0] v;
        logic          prev;
        logic [3:0]    c;
        test_en = 0; test_clk = 0; test_exec = 0; test_in = 0;
        pad_in = '0; func_oe = '0; func_d1 = 0; func_d2 = 0;

        // R8: the starting state is normal pass-through.
        apply(4'b0000, '0, 32'hA5A5_0F0F, 1'b1, 1'b0, "R8 start");
        apply(4'b0000, '1, 32'h1234_5678, 1'b0, 1'b1, "R8 pass");

        // R1: every code that misses the entry code by one bit stays normal.
        for (int b = 0; b < 4; b++) begin
            c = 4'b1011 ^ (4'b1 << b);
            apply(c, '1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R1 near miss");
        end
        apply(4'b1111, '1, 32'h0000_0001, 1'b1, 1'b1, "R1 clk high");

        // R4, R6, R7: all inputs high in test mode.
        apply(4'b1011, '1, 32'hFFFF_FFFF, 1'b0, 1'b0, "R4 R6 all ones");
        apply(4'b1011, '1, 32'h0000_0000, 1'b1, 1'b1, "R6 R7 tdo off");

        // R2: a single zero walked through chain one, then chain two.
        for (int p = 1; p <= L1; p++) begin
            v = '1; v[p-1] = 1'b0;
            apply(4'b1011, v, 32'hDEAD_BEEF, 1'b0, 1'b1, "R2 chain1 single zero");
        end
        for (int p = 1; p <= L2; p++) begin
            v = '1; v[L1+p-1] = 1'b0;
            apply(4'b1011, v, 32'h0F0F_F0F1, 1'b1, 1'b0, "R2 chain2 single zero");
        end

        // R3: cumulative zeros from position 1 flip the result each step.
        v = '1;
        prev = 1'b1;
        for (int p = 1; p <= L1; p++) begin
            v[p-1] = 1'b0;
            if (chain_ref(v, 0, L1) == prev) begin
                n_checks++; n_errors++;
                $display("FAIL R3 model: got %b expected %b", prev, ~prev);
            end
            prev = chain_ref(v, 0, L1);
            apply(4'b1011, v, 32'h5555_5555, 1'b0, 1'b0, "R3 chain1 walk");
        end
        v = '1;
        for (int p = 1; p <= L2; p++) begin
            v[L1+p-1] = 1'b0;
            apply(4'b1011, v, 32'hAAAA_AAAA, 1'b0, 1'b0, "R3 chain2 walk");
        end

        // R5: position 10 of chain one strapped low masks positions 1..9.
        for (int k = 0; k < 12; k++) begin
            v = '1; v[9] = 1'b0;
            v[8:0] = 9'($urandom);
            apply(4'b1011, v, 32'h0, 1'b0, 1'b0, "R5 strap mask");
        end

        // R9: chain two patterns vary while chain one stays all ones.
        for (int k = 0; k < 10; k++) begin
            v = '1;
            v[NI-1:L1] = 16'($urandom);
            apply(4'b1011, v, 32'($urandom), 1'b0, 1'b0, "R9 independence");
        end

        // Same-step exit: code, pads and functional values change together (R8).
        v = '1; v[4:0] = '0;
        apply(4'b1011, v, 32'h0000_0007, 1'b0, 1'b0, "R7 before exit");
        apply(4'b0011, '0, 32'hC3C3_3C3C, 1'b1, 1'b0, "R8 same step exit");
        apply(4'b1011, '1, 32'hFFFF_FFFE, 1'b0, 1'b1, "R6 re-entry");
        apply(4'b1010, '1, 32'h8000_0001, 1'b0, 1'b1, "R8 exit din low");

        wait (sb_q.size() == 0);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule